// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A clock-enable pulse, `tick_i`, runs at either sixteen or eight times the bit rate, and the block counts these pulses to find the middle of each bit.

The line first passes through a two-stage synchronizer. A high-to-low transition on the idle line arms the receiver. The block then checks the line again at the middle of the start bit and throws away any start that has already gone high by then. After that it samples each data bit, the optional parity bit and the stop bit at their centres.

For each character the block presents a byte, three error flags and a single-cycle valid pulse. These stay held until the next character arrives. The host sets word length, parity and oversampling ratio, and keeps them steady while a character is in flight.

Top module: `uart_os_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `valid_o` is 0, `data_o` is 0 and all three error flags are 0.
- R2: Reception begins only on a high-to-low change of the synchronized line. The bit-timing counter advances only in cycles where `tick_i` is 1, so a frame sent while `tick_i` is held low produces no character.
- R3: If the line is high again when the start-bit centre is sampled, the start is discarded. No character is produced and the receiver waits for a new falling edge.
- R4: With `mode8x_i`=0, the start-bit centre is taken 8 ticks after the edge is seen, and every later bit 16 ticks after the previous sample.
- R5: With `mode8x_i`=1, the start-bit centre is taken 4 ticks after the edge is seen, and every later bit 8 ticks after the previous sample.
- R6: `wlen_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first received data bit lands in `data_o[0]`, and bits above the word length read 0.
- R7: With `par_en_i`=1, one parity bit follows the data. `par_odd_i`=0 expects an even count of ones over data plus parity; 1 expects an odd count. A mismatch sets `err_parity_o`.
- R8: With `par_en_i`=0, no parity bit is sampled, the stop bit follows the last data bit directly, and `err_parity_o` is 0.
- R9: `err_frame_o` is 1 exactly when the stop-bit sample is low.
- R10: `err_break_o` is 1 exactly when every data, parity (if enabled) and stop sample of the character is low. A break therefore always carries a framing error and a zero byte.
- R11: `valid_o` is high for a single cycle per character. `data_o` and the flags hold their values until the next pulse.
- R12: With one tick per clock, `valid_o` rises 2 + H + B·(N + P + 1) cycles after the first clock edge at which `rxd_i` is low. Here H is 8 or 4, B is 16 or 8, N is the data-bit count and P is 1 if parity is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversample clock enable |
| mode8x_i | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wlen_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 for odd parity, 0 for even |
| data_o | output | 8 | Received byte, LSB first on the line |
| err_parity_o | output | 1 | Parity mismatch for this byte |
| err_frame_o | output | 1 | Stop bit sampled low |
| err_break_o | output | 1 | All samples of the character low |
| valid_o | output | 1 | One-cycle pulse: new byte and flags |

## Verification
Each character's result is due a fixed number of cycles after the first clock edge that sees the line low. That delay is two synchronizer cycles, plus half a bit to the start-bit centre, plus one full bit period for every data, parity and stop bit.

The bench records that edge as it drives each frame and schedules the expected byte, flags and cycle number. On every clock, between edges, it compares `valid_o` with whether a character is due in that cycle. It also compares the byte and the flags against the last character due, so an early pulse, a late pulse, a missing pulse or a stray pulse is each caught in the exact cycle where it appears.

// File: rtl/uart_os_rx.sv
module uart_os_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  input  logic       tick_i,
  input  logic       mode8x_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic [7:0] data_o,
  output logic       err_parity_o,
  output logic       err_frame_o,
  output logic       err_break_o,
  output logic       valid_o
);
  localparam int CW = 4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic          sy1, sy2, sy_prev;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          par_bit, any_hi;

  wire [CW-1:0] half_m1 = mode8x_i ? CW'(3) : CW'(7);
  wire [CW-1:0] full_m1 = mode8x_i ? CW'(7) : CW'(15);
  wire [CW-1:0] lim     = (st == S_START) ? half_m1 : full_m1;
  wire          at_mid  = tick_i && (cnt == lim);
  wire [2:0]    last_i  = {1'b0, wlen_i} + 3'd4;
  wire          fall    = sy_prev && !sy2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1; sy2 <= 1'b1; sy_prev <= 1'b1;
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0;
      par_bit <= 1'b0; any_hi <= 1'b0;
      data_o <= '0; err_parity_o <= 1'b0; err_frame_o <= 1'b0;
      err_break_o <= 1'b0; valid_o <= 1'b0;
    end else begin
      sy1 <= rxd_i;
      sy2 <= sy1;
      sy_prev <= sy2;
      valid_o <= 1'b0;
      if (st != S_IDLE && tick_i)
        cnt <= at_mid ? '0 : cnt + CW'(1);
      case (st)
        S_IDLE: if (fall) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (at_mid) begin
          if (sy2) st <= S_IDLE;
          else begin
            st <= S_DATA; bidx <= '0; shreg <= '0;
            par_bit <= 1'b0; any_hi <= 1'b0;
          end
        end
        S_DATA: if (at_mid) begin
          shreg[bidx] <= sy2;
          any_hi <= any_hi | sy2;
          if (bidx == last_i) st <= par_en_i ? S_PAR : S_STOP;
          else bidx <= bidx + 3'd1;
        end
        S_PAR: if (at_mid) begin
          par_bit <= sy2;
          any_hi  <= any_hi | sy2;
          st      <= S_STOP;
        end
        S_STOP: if (at_mid) begin
          data_o       <= shreg;
          err_parity_o <= par_en_i && ((^shreg ^ par_bit) != par_odd_i);
          err_frame_o  <= !sy2;
          err_break_o  <= !(any_hi | sy2);
          valid_o      <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] wlen_i,
  input logic       par_en_i,
  input logic [7:0] data_o,
  input logic       err_parity_o,
  input logic       err_frame_o,
  input logic       err_break_o,
  input logic       valid_o
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o));
  a_r11_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable({err_parity_o, err_frame_o, err_break_o}));
  a_r10_break_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_break_o) |-> (err_frame_o && data_o == 8'h00));
  a_r8_no_parity_err: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !par_en_i) |-> !err_parity_o);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_i == 2'd0) |-> (data_o[7:5] == 3'b000));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && data_o == 8'h00));
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wlen_i(wlen_i), .par_en_i(par_en_i),
  .data_o(data_o), .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
  .err_break_o(err_break_o), .valid_o(valid_o)
);

// File: tb/uart_os_rx_bench.sv
`timescale 1ns/1ps
module uart_os_rx_bench;
  logic clk = 0, rst_n = 0, rxd = 1, tick = 1, m8 = 0, pen = 0, podd = 0;
  logic [1:0] wlen = 2'd3;
  logic [7:0] data;
  logic perr, ferr, brk, valid;

  always #5 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick), .mode8x_i(m8),
    .wlen_i(wlen), .par_en_i(pen), .par_odd_i(podd), .data_o(data),
    .err_parity_o(perr), .err_frame_o(ferr), .err_break_o(brk), .valid_o(valid)
  );

  typedef struct { int due; logic [7:0] d; logic pe, fe, bk; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;
  logic [10:0] last_exp = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && !finished) begin
    bit due;
    due = (q.size() > 0) && (q[0].due == cyc);
    total++;
    if (valid !== due) begin
      bad++;
      $display("FAIL %s valid at cycle %0d: actual=%0b expected=%0b",
               due ? q[0].tag : "R2/R3/R11 stray", cyc, valid, due);
    end
    if (due) begin
      last_exp = {q[0].d, q[0].pe, q[0].fe, q[0].bk};
      total++;
      if ({data, perr, ferr, brk} !== last_exp) begin
        bad++;
        $display("FAIL %s byte/flags: actual=%h/%b%b%b expected=%h/%b%b%b",
                 q[0].tag, data, perr, ferr, brk,
                 q[0].d, q[0].pe, q[0].fe, q[0].bk);
      end
      void'(q.pop_front());
    end else if ({data, perr, ferr, brk} !== last_exp) begin
      total++; bad++;
      $display("FAIL R11 hold: actual=%h/%b%b%b expected=%h/%b%b%b", data,
               perr, ferr, brk, last_exp[10:3], last_exp[2], last_exp[1], last_exp[0]);
    end
    if (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
  end

  task automatic drive(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input logic pe,
                       input logic po, input logic flip, input logic stopv,
                       input logic x8, input bit expect_it, input string tag);
    int b, h, e;
    logic [7:0] dm;
    logic pb;
    b = x8 ? 8 : 16; h = b / 2;
    m8 = x8; wlen = 2'(nb - 5); pen = pe; podd = po;
    dm = d & 8'((1 << nb) - 1);
    pb = (^dm) ^ po ^ flip;
    e = cyc + 1;
    if (expect_it)
      q.push_back('{e + 2 + h + b * (nb + (pe ? 1 : 0) + 1), dm, pe && flip,
                    !stopv, (dm == 0) && (!pe || !pb) && !stopv, tag});
    drive(1'b0, b);
    for (int i = 0; i < nb; i++) drive(dm[i], b);
    if (pe) drive(pb, b);
    drive(stopv, b);
    drive(1'b1, 3 * b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({valid, data, perr, ferr, brk} !== 12'h0) begin
      bad++; $display("FAIL R1 reset outputs: actual=%h expected=0", {valid, data, perr, ferr, brk});
    end
    rst_n = 1;
    @(negedge clk);
    total++;
    if ({valid, data, perr, ferr, brk} !== 12'h0) begin
      bad++; $display("FAIL R1 after reset: actual=%h expected=0", {valid, data, perr, ferr, brk});
    end
    repeat (5) @(negedge clk);
    frame(8'hA5, 8, 0, 0, 0, 1, 0, 1, "R4 R8 R12 8bit none");
    frame(8'h13, 5, 1, 0, 0, 1, 0, 1, "R6 R7 5bit even");
    frame(8'h2C, 6, 1, 1, 0, 1, 0, 1, "R6 R7 6bit odd");
    frame(8'h5A, 7, 1, 0, 1, 1, 0, 1, "R7 parity error");
    frame(8'hFF, 5, 0, 0, 0, 1, 0, 1, "R6 upper zero");
    frame(8'h3C, 8, 0, 0, 0, 0, 0, 1, "R9 framing");
    frame(8'h00, 8, 1, 0, 0, 0, 0, 1, "R10 break even");
    frame(8'h00, 5, 1, 1, 0, 0, 0, 1, "R10 break odd");
    frame(8'h00, 6, 0, 0, 0, 1, 0, 1, "R10 zero not break");
    // R3 false start, 16X then 8X
    drive(1'b0, 3); drive(1'b1, 40);
    m8 = 1; drive(1'b0, 2); drive(1'b1, 30);
    frame(8'hC3, 8, 1, 1, 0, 1, 1, 1, "R5 8X odd");
    frame(8'h1F, 5, 0, 0, 0, 1, 1, 1, "R5 8X 5bit");
    frame(8'h66, 7, 1, 0, 1, 0, 1, 1, "R5 R7 R9 8X");
    // R2: no ticks, no character; then a late tick burst sees idle line
    tick = 0;
    frame(8'h81, 8, 0, 0, 0, 1, 0, 0, "R2 no tick");
    repeat (20) @(negedge clk);
    tick = 1;
    repeat (60) @(negedge clk);
    frame(8'h96, 8, 1, 0, 0, 1, 0, 1, "R2 R12 after stall");
    repeat (20) @(negedge clk);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12 missing characters: actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule